// File: doc/BRIEF.md
# Two-Level FM Line Transmit Modulator

This block turns a serial bit stream from a frame controller into a two-level frequency-shift line code. Every bit changes polarity at its boundary. A zero bit also changes polarity in the middle of the bit; a one bit does not.

The block builds a bit clock at half the carrier-strobe rate. The controller uses this clock to present each new data bit. The block also handles the request-to-send and clear-to-send handshake. After the request rises, clear-to-send stays low for a programmable number of bit periods. During that time the line already carries the code for the current data level, so the far-end receiver can lock. An end-of-transfer pulse withdraws clear-to-send.

The block runs on one master clock. It takes two single-cycle tick enables: a carrier strobe that paces the bit clock, and a toggle strobe that clocks the line flip-flop.

Top module: `fm_line_modulator`

## Requirements
- R1: After reset, `bit_clk`, `line_out`, `cts` and `rts_out` are all 0.
- R2: `bit_clk` inverts on the clock edge where `carrier_tick` is 1 and holds otherwise, whatever the level of `rts_in`.
- R3: While `rts_in` is 1, a `toggle_tick` inverts `line_out` under either of two conditions: `tx_data` is 0, or `tx_data` is 1 and `bit_clk` is 1. When `tx_data` is 1 and `bit_clk` is 0, `line_out` holds.
- R4: While `rts_in` is 0, `line_out` goes to 0 on the next clock edge and stays there.
- R5: `line_out` never changes on an edge without `toggle_tick`, unless R4 clears it.
- R6: While `rts_in` is 1, an edge counts as one bit period when `carrier_tick` is 1 and `bit_clk` is 0, which is the edge where `bit_clk` rises. `cts` rises in the cycle after the edge that brings the count to `CTS_PERIODS` (default 32). It then stays high while `rts_in` remains 1.
- R7: A `dend` of 1 while `rts_in` is 1 makes `cts` 0 from the next cycle. `cts` stays 0 until `rts_in` has been low, even if the count has not yet been reached.
- R8: `cts` is 0 in any cycle where `rts_in` is 0. Dropping `rts_in` clears the period count, so a new request waits a full delay.
- R9: `rts_out` equals `rts_in` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_tick | input | 1 | Carrier strobe, one cycle wide |
| toggle_tick | input | 1 | Line flip-flop strobe, one cycle wide |
| tx_data | input | 1 | Serial transmit data from the controller |
| rts_in | input | 1 | Request to send from the controller |
| dend | input | 1 | End-of-transfer pulse |
| line_out | output | 1 | Modulated transmit line level |
| bit_clk | output | 1 | Bit clock to the controller |
| cts | output | 1 | Clear to send |
| rts_out | output | 1 | Request to send toward the line |

## Verification
The stimulus mixes three kinds of input:
- long runs of steady zeros and steady ones, which separate the mid-bit toggle of a zero from the boundary-only toggle of a one;
- random data against random tick patterns, which shows whether toggles gate on the bit-clock phase and not on the tick alone;
- directed request sequences, which place the end-of-transfer pulse before, at and after the delay expires, and drop the request in mid-count, which separates a restarted count from a resumed one.

The carrier strobe also runs while the request is low. This shows that the bit clock never stops.

// File: rtl/fm_line_pkg.sv
package fm_line_pkg;

  // Toggle condition for the line flip-flop: always for a zero bit,
  // only during the high half of the bit clock for a one bit.
  function automatic logic tx_cond_f(input logic data, input logic bclk);
    return data ? bclk : 1'b1;
  endfunction

  // Next line level for one master-clock edge.
  function automatic logic line_next_f(input logic cur, input logic enable,
                                       input logic tick, input logic cond);
    if (!enable) return 1'b0;
    if (tick && cond) return ~cur;
    return cur;
  endfunction

  // Saturating increment for the clear-to-send period counter.
  function automatic int unsigned sat_inc_f(input int unsigned cur,
                                            input int unsigned limit);
    return (cur >= limit) ? limit : cur + 1;
  endfunction

endpackage

// File: rtl/fm_bitclk_gen.sv
module fm_bitclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_tick,
  output logic bit_clk,
  output logic bit_rise
);
  logic bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            bclk_q <= 1'b0;
    else if (carrier_tick) bclk_q <= ~bclk_q;
  end

  // The edge that will take the bit clock from low to high.
  assign bit_rise = carrier_tick & ~bclk_q;
  assign bit_clk  = bclk_q;
endmodule

// File: rtl/fm_half_bit_toggle.sv
module fm_half_bit_toggle
  import fm_line_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic toggle_tick,
  input  logic tx_data,
  input  logic bit_clk,
  output logic tx_cond,
  output logic line_out
);
  logic line_q;

  assign tx_cond = tx_cond_f(tx_data, bit_clk);

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_next_f(line_q, enable, toggle_tick, tx_cond);
  end

  assign line_out = line_q;
endmodule

// File: rtl/fm_cts_gate.sv
module fm_cts_gate
  import fm_line_pkg::*;
#(
  parameter int unsigned CTS_PERIODS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rts_in,
  input  logic bit_rise,
  input  logic dend,
  output logic delay_done,
  output logic ended,
  output logic cts
);
  localparam int unsigned CW = $clog2(CTS_PERIODS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CTS_PERIODS);

  logic [CW-1:0] cnt_q;
  logic          end_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !rts_in) begin
      cnt_q <= '0;
      end_q <= 1'b0;
    end else begin
      if (bit_rise) cnt_q <= CW'(sat_inc_f(int'(cnt_q), CTS_PERIODS));
      if (dend)     end_q <= 1'b1;
    end
  end

  assign delay_done = (cnt_q == LIMIT);
  assign ended      = end_q;
  assign cts        = rts_in & delay_done & ~end_q;
endmodule

// File: rtl/fm_line_modulator.sv
module fm_line_modulator #(
  parameter int unsigned CTS_PERIODS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_tick,
  input  logic toggle_tick,
  input  logic tx_data,
  input  logic rts_in,
  input  logic dend,
  output logic line_out,
  output logic bit_clk,
  output logic cts,
  output logic rts_out
);
  logic bit_rise;
  logic tx_cond;
  logic delay_done;
  logic ended;
  logic rts_q;

  fm_bitclk_gen u_bclk (
    .clk          (clk),
    .rst_n        (rst_n),
    .carrier_tick (carrier_tick),
    .bit_clk      (bit_clk),
    .bit_rise     (bit_rise)
  );

  fm_half_bit_toggle u_fm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (rts_in),
    .toggle_tick (toggle_tick),
    .tx_data     (tx_data),
    .bit_clk     (bit_clk),
    .tx_cond     (tx_cond),
    .line_out    (line_out)
  );

  fm_cts_gate #(.CTS_PERIODS(CTS_PERIODS)) u_cts (
    .clk        (clk),
    .rst_n      (rst_n),
    .rts_in     (rts_in),
    .bit_rise   (bit_rise),
    .dend       (dend),
    .delay_done (delay_done),
    .ended      (ended),
    .cts        (cts)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rts_q <= 1'b0;
    else        rts_q <= rts_in;
  end

  assign rts_out = rts_q;
endmodule

// File: rtl/fm_line_modulator_chk.sv
module fm_line_modulator_chk (
  input logic clk,
  input logic rst_n,
  input logic carrier_tick,
  input logic toggle_tick,
  input logic tx_data,
  input logic rts_in,
  input logic dend,
  input logic line_out,
  input logic bit_clk,
  input logic cts,
  input logic rts_out,
  input logic delay_done
);
  p_bclk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_tick |=> bit_clk != $past(bit_clk));

  p_bclk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_tick |=> $stable(bit_clk));

  p_zero_toggles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_in && toggle_tick && !tx_data) |=> line_out != $past(line_out));

  p_one_low_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_in && tx_data && !bit_clk) |=> $stable(line_out));

  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_in |=> !line_out);

  p_no_tick_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_in && !toggle_tick) |=> $stable(line_out));

  p_cts_after_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cts |-> delay_done);

  p_dend_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_in && dend) |=> !cts);

  p_cts_needs_rts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_in |-> !cts);

  p_rts_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rts_out == $past(rts_in));
endmodule

bind fm_line_modulator fm_line_modulator_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .carrier_tick (carrier_tick),
  .toggle_tick  (toggle_tick),
  .tx_data      (tx_data),
  .rts_in       (rts_in),
  .dend         (dend),
  .line_out     (line_out),
  .bit_clk      (bit_clk),
  .cts          (cts),
  .rts_out      (rts_out),
  .delay_done   (delay_done)
);

// File: tb/fm_line_modulator_tb_top.sv
`timescale 1ns/1ps
module fm_line_modulator_tb_top;
  localparam int unsigned N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carrier_tick = 1'b0, toggle_tick = 1'b0, tx_data = 1'b0;
  logic rts_in = 1'b0, dend = 1'b0;
  logic line_out, bit_clk, cts, rts_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // Reference state, built from the requirements
  logic e_bclk = 1'b0, e_line = 1'b0, e_rtso = 1'b0, e_end = 1'b0;
  int   e_cnt = 0;

  always #2.5 clk = ~clk;

  fm_line_modulator #(.CTS_PERIODS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick),
    .toggle_tick(toggle_tick), .tx_data(tx_data), .rts_in(rts_in),
    .dend(dend), .line_out(line_out), .bit_clk(bit_clk), .cts(cts),
    .rts_out(rts_out)
  );

  function automatic logic m_line(input logic cur, input logic rts,
                                  input logic tick, input logic d,
                                  input logic b);
    // R3/R4/R5: zero toggles on every tick, one only with bit clock high
    if (!rts) return 1'b0;
    if (!tick) return cur;
    if (d == 1'b0 || b == 1'b1) return !cur;
    return cur;
  endfunction

  function automatic logic m_cts(input logic rts, input int cnt,
                                 input logic ended);
    return rts && (cnt == N) && !ended;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_bclk <= 1'b0; e_line <= 1'b0; e_rtso <= 1'b0;
      e_cnt <= 0; e_end <= 1'b0;
    end else begin
      e_line <= m_line(e_line, rts_in, toggle_tick, tx_data, e_bclk);
      e_bclk <= carrier_tick ? !e_bclk : e_bclk;
      e_rtso <= rts_in;
      if (!rts_in) begin
        e_cnt <= 0; e_end <= 1'b0;
      end else begin
        if (carrier_tick && !e_bclk && e_cnt < N) e_cnt <= e_cnt + 1;
        if (dend) e_end <= 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle %0d actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 bit_clk", bit_clk, e_bclk);
    chk(rts_in ? "R3 line_out" : "R4 line_out", line_out, e_line);
    chk(rts_in ? "R6/R7 cts" : "R8 cts", cts, m_cts(rts_in, e_cnt, e_end));
    chk("R9 rts_out", rts_out, e_rtso);
  endtask

  // One cycle: check at the falling edge, then drive new inputs
  task automatic step(input logic c, input logic t, input logic d,
                      input logic r, input logic de);
    @(negedge clk);
    cyc++;
    check_all();
    carrier_tick = c; toggle_tick = t; tx_data = d; rts_in = r; dend = de;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    logic r;
    seed_dummy = $urandom(32'h5A17);
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 line_out", line_out, 1'b0);
    chk("R1 bit_clk", bit_clk, 1'b0);
    chk("R1 cts", cts, 1'b0);
    chk("R1 rts_out", rts_out, 1'b0);
    rst_n = 1'b1;

    // R2: bit clock runs with the request low, R4 line stays low
    for (int i = 0; i < 20; i++) step(i[0], 1'b1, 1'b0, 1'b0, 1'b0);

    // R3: steady zeros then steady ones, ticks on every cycle
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    // R6: count reaches the limit with the carrier on every cycle
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R6 cts high after delay", cts, 1'b1);
    // R7: end-of-transfer drops it and holds
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R7 cts held low", cts, 1'b0);
    // R8: drop the request in mid-count, restart
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 100; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 cts after full restart", cts, 1'b1);
    // R7: end-of-transfer before the delay expires blocks it
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 100; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 early end blocks cts", cts, 1'b0);

    // Random mix
    r = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(399) == 0) r = !r;
      step(1'($urandom_range(1)), 1'($urandom_range(2) != 0),
           1'($urandom_range(1)), r, 1'($urandom_range(299) == 0));
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule